// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block drives an 8-bit parallel character display (a 16x2 module with the common command/data bus) from a synchronous clock. After a synchronous reset it waits out the display's power-up time. It then runs a fixed script of eight bus writes: four set-up commands, followed by four text characters. Each write places a byte and a register-select level on the bus, keeps the read/write line low, and strobes the enable line high and then low. All timing comes from a clock-cycle counter.

Every interval is given in nanoseconds as a parameter. At elaboration each one is converted to a whole number of clock cycles, rounded upwards. The enable pulse therefore never falls short of its minimum width, whatever the clock period. After the last character the block raises a done flag and stays idle until the next reset.

Top module: `lcd_write_seq`

## Requirements
- R1: The first four transfers carry the command bytes 0x38, 0x01, 0x06, 0x0C, in that order.
- R2: Transfers five to eight carry the character bytes 0x53, 0x48, 0x52, 0x49, in that order.
- R3: The register-select output is 0 during command transfers and 1 during character transfers.
- R4: The read/write output is 0 at all times.
- R5: Each enable pulse stays high for at least E_HIGH_CYC = ceil(E_MIN_NS*1000/CLK_PERIOD_PS) clock cycles. With the defaults this is 113 cycles.
- R6: The data and register-select outputs do not change while enable is high.
- R7: Data and register-select settle at least SETUP_CYC cycles before enable rises. They stay unchanged for at least HOLD_CYC cycles after enable falls.
- R8: Between an enable fall and the next enable rise, enable stays low for at least the execution wait of the byte just written. The 0x01 command uses the wait from CLEAR_EXEC_NS. Every other byte uses the wait from CMD_EXEC_NS.
- R9: After reset is released, the first enable rise comes no earlier than the cycle count derived from POWERON_NS.
- R10: Exactly eight enable pulses occur per run. After the eighth execution wait, done goes to 1 and enable stays 0 until reset.
- R11: A synchronous reset, even in the middle of a run, forces enable and done to 0 and restarts the script from the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lcdData | output | 8 | Byte driven onto the display bus |
| lcdRs | output | 1 | Register select: 0 command, 1 character |
| lcdRw | output | 1 | Read/write, always 0 (write) |
| lcdEn | output | 1 | Enable strobe |
| done | output | 1 | Script finished; held until reset |

## Verification
The hardest condition to reach from the ports is a reset that lands partway through the script, for example while enable is high or during the long wait after the clear command. The restart must then begin again at the first command and repeat the full power-on wait. The bench runs a clean pass first. It then draws reset instants from a seeded $urandom across the whole run length and asserts reset at each one. For every restart it checks the byte order, the select levels, the pulse widths and the gaps, and it also checks the idle state while reset is held.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int unsigned SCRIPT_LEN = 8;
  localparam int unsigned CMD_LEN    = 4;
  localparam logic [7:0]  CLEAR_OP   = 8'h01;

  typedef enum logic [2:0] {
    ST_PWRON,
    ST_LOAD,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_EXEC,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    TM_SETUP,
    TM_PULSE,
    TM_HOLD,
    TM_EXEC
  } tmrSel_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic    tmrLoad;
    tmrSel_t tmrSel;
    logic    busLoad;
    logic    stepAdv;
    logic    eSet;
    logic    eClr;
    logic    doneSet;
  } seqCtl_t;

  // Script contents: set-up commands first, then the text
  function automatic logic [7:0] scriptByte(input int unsigned idx);
    case (idx)
      0:       return 8'h38;
      1:       return CLEAR_OP;
      2:       return 8'h06;
      3:       return 8'h0C;
      4:       return 8'h53;
      5:       return 8'h48;
      6:       return 8'h52;
      default: return 8'h49;
    endcase
  endfunction

  function automatic logic scriptIsChar(input int unsigned idx);
    return idx >= CMD_LEN;
  endfunction

  // Nanoseconds to whole cycles, rounded up, never below one
  function automatic int unsigned nsToCycles(input longint unsigned ns,
                                             input longint unsigned periodPs);
    longint unsigned c;
    c = (ns * 64'd1000 + periodPs - 64'd1) / periodPs;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int unsigned           W       = 8,
  parameter logic [W-1:0]          RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= RST_VAL;
    else if (load)         cnt <= loadVal;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned POWERON_CY = 4,
  parameter int unsigned SETUP_CY   = 1,
  parameter int unsigned EHIGH_CY   = 2,
  parameter int unsigned HOLD_CY    = 1,
  parameter int unsigned CMD_CY     = 4,
  parameter int unsigned CLEAR_CY   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  seqCtl_t    ctl,
  output logic [7:0] lcdData,
  output logic       lcdRs,
  output logic       lcdEn,
  output logic       done,
  output logic       tmrZero,
  output logic       lastStep
);
  localparam int unsigned STEP_W = $clog2(SCRIPT_LEN);
  localparam logic [TMR_W-1:0] PWR_LD   = TMR_W'(POWERON_CY - 1);
  localparam logic [TMR_W-1:0] SETUP_LD = TMR_W'(SETUP_CY - 1);
  localparam logic [TMR_W-1:0] EHIGH_LD = TMR_W'(EHIGH_CY - 1);
  localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CY - 1);
  localparam logic [TMR_W-1:0] CMD_LD   = TMR_W'(CMD_CY - 1);
  localparam logic [TMR_W-1:0] CLEAR_LD = TMR_W'(CLEAR_CY - 1);

  logic [STEP_W-1:0] stepIdx;
  logic [TMR_W-1:0]  tmrVal;

  always_ff @(posedge clk) begin
    if (rst)              stepIdx <= '0;
    else if (ctl.stepAdv) stepIdx <= stepIdx + 1'b1;
  end

  assign lastStep = (stepIdx == STEP_W'(SCRIPT_LEN - 1));

  // Bus byte and select are registered together from the step index
  always_ff @(posedge clk) begin
    if (rst) begin
      lcdData <= '0;
      lcdRs   <= 1'b0;
    end else if (ctl.busLoad) begin
      lcdData <= scriptByte(int'(stepIdx));
      lcdRs   <= scriptIsChar(int'(stepIdx));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           lcdEn <= 1'b0;
    else if (ctl.eSet) lcdEn <= 1'b1;
    else if (ctl.eClr) lcdEn <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)              done <= 1'b0;
    else if (ctl.doneSet) done <= 1'b1;
  end

  always_comb begin
    case (ctl.tmrSel)
      TM_SETUP: tmrVal = SETUP_LD;
      TM_PULSE: tmrVal = EHIGH_LD;
      TM_HOLD:  tmrVal = HOLD_LD;
      default:  tmrVal = (lcdData == CLEAR_OP) ? CLEAR_LD : CMD_LD;
    endcase
  end

  lcd_seq_timer #(
    .W       (TMR_W),
    .RST_VAL (PWR_LD)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (ctl.tmrLoad),
    .loadVal (tmrVal),
    .zero    (tmrZero)
  );
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tmrZero,
  input  logic    lastStep,
  output seqCtl_t ctl
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PWRON;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ctl.tmrSel = TM_SETUP;
    case (state)
      ST_PWRON: if (tmrZero) stateNext = ST_LOAD;
      ST_LOAD: begin
        ctl.busLoad = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TM_SETUP;
        stateNext   = ST_SETUP;
      end
      ST_SETUP: if (tmrZero) begin
        ctl.eSet    = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TM_PULSE;
        stateNext   = ST_PULSE;
      end
      ST_PULSE: if (tmrZero) begin
        ctl.eClr    = 1'b1;
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TM_HOLD;
        stateNext   = ST_HOLD;
      end
      ST_HOLD: if (tmrZero) begin
        ctl.tmrLoad = 1'b1;
        ctl.tmrSel  = TM_EXEC;
        stateNext   = ST_EXEC;
      end
      ST_EXEC: if (tmrZero) begin
        if (lastStep) begin
          ctl.doneSet = 1'b1;
          stateNext   = ST_DONE;
        end else begin
          ctl.stepAdv = 1'b1;
          stateNext   = ST_LOAD;
        end
      end
      default: stateNext = ST_DONE;
    endcase
  end
endmodule

// File: rtl/lcd_write_seq.sv
module lcd_write_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned E_MIN_NS      = 450,
  parameter int unsigned POWERON_NS    = 15_000_000,
  parameter int unsigned CMD_EXEC_NS   = 40_000,
  parameter int unsigned CLEAR_EXEC_NS = 1_600_000,
  parameter int unsigned SETUP_CYC     = 1,
  parameter int unsigned HOLD_CYC      = 1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] lcdData,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  output logic       done
);
  localparam int unsigned E_HIGH_CYC  = nsToCycles(E_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned POWERON_CYC = nsToCycles(POWERON_NS, CLK_PERIOD_PS);
  localparam int unsigned CMD_CYC     = nsToCycles(CMD_EXEC_NS, CLK_PERIOD_PS);
  localparam int unsigned CLEAR_CYC   = nsToCycles(CLEAR_EXEC_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC     =
      maxOf(maxOf(maxOf(E_HIGH_CYC, POWERON_CYC), maxOf(CMD_CYC, CLEAR_CYC)),
            maxOf(SETUP_CYC, HOLD_CYC));
  localparam int unsigned TMR_W = $clog2(MAX_CYC + 1);

  seqCtl_t ctl;
  logic    tmrZero;
  logic    lastStep;

  assign lcdRw = 1'b0;

  lcd_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tmrZero  (tmrZero),
    .lastStep (lastStep),
    .ctl      (ctl)
  );

  lcd_seq_dp #(
    .TMR_W      (TMR_W),
    .POWERON_CY (POWERON_CYC),
    .SETUP_CY   (SETUP_CYC),
    .EHIGH_CY   (E_HIGH_CYC),
    .HOLD_CY    (HOLD_CYC),
    .CMD_CY     (CMD_CYC),
    .CLEAR_CY   (CLEAR_CYC)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .lcdData  (lcdData),
    .lcdRs    (lcdRs),
    .lcdEn    (lcdEn),
    .done     (done),
    .tmrZero  (tmrZero),
    .lastStep (lastStep)
  );
endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int unsigned E_HIGH_CYC = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] lcdData,
  input logic       lcdRs,
  input logic       lcdEn,
  input logic       done
);
  int unsigned hiCnt;

  always_ff @(posedge clk) begin
    if (rst)        hiCnt <= 0;
    else if (lcdEn) hiCnt <= hiCnt + 1;
    else            hiCnt <= 0;
  end

  AST_E_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdEn) |-> hiCnt >= E_HIGH_CYC);  // R5

  AST_BUS_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (lcdEn && $past(lcdEn)) |-> ($stable(lcdData) && $stable(lcdRs)));  // R6

  AST_BUS_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(lcdEn) |-> ($stable(lcdData) && $stable(lcdRs)));  // R7

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(lcdEn) |=> ($stable(lcdData) && $stable(lcdRs)));  // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done);  // R10

  AST_DONE_E_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> !lcdEn);  // R10
endmodule

bind lcd_write_seq lcd_seq_chk #(.E_HIGH_CYC(E_HIGH_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .lcdData (lcdData),
  .lcdRs   (lcdRs),
  .lcdEn   (lcdEn),
  .done    (done)
);

// File: tb/lcd_write_seq_tb.sv
`timescale 1ns/1ps
module lcd_write_seq_tb;
  // Shortened timing: 250 MHz clock, 4 ns period
  localparam int unsigned EXP_EHIGH = 113;  // ceil(450 / 4)
  localparam int unsigned EXP_PWR   = 100;  // 400 ns
  localparam int unsigned EXP_CMD   = 100;  // 400 ns
  localparam int unsigned EXP_CLEAR = 500;  // 2000 ns

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lcdData;
  logic       lcdRs, lcdRw, lcdEn, done;

  int unsigned nTests = 0;
  int unsigned nFail  = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  lcd_write_seq #(
    .CLK_PERIOD_PS (4000),
    .E_MIN_NS      (450),
    .POWERON_NS    (400),
    .CMD_EXEC_NS   (400),
    .CLEAR_EXEC_NS (2000),
    .SETUP_CYC     (1),
    .HOLD_CYC      (1)
  ) u_dut (
    .clk (clk), .rst (rst), .lcdData (lcdData), .lcdRs (lcdRs),
    .lcdRw (lcdRw), .lcdEn (lcdEn), .done (done)
  );

  function automatic logic [7:0] expByte(input int idx);
    case (idx)
      0: return 8'h38; 1: return 8'h01; 2: return 8'h06; 3: return 8'h0C;
      4: return 8'h53; 5: return 8'h48; 6: return 8'h52; default: return 8'h49;
    endcase
  endfunction

  function automatic logic expRs(input int idx);
    return idx >= 4;
  endfunction

  function automatic int unsigned expWait(input int idx);
    return (expByte(idx) == 8'h01) ? EXP_CLEAR : EXP_CMD;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bus monitor, sampling on the falling clock edge
  int          xferIdx = 0;
  int unsigned hiCnt = 0, loCnt = 0, pwrCnt = 0;
  logic        prevE = 1'b0, prevRs = 1'b0, latRs = 1'b0;
  logic [7:0]  prevData = '0, latData = '0;
  bit          holdPending = 1'b0, unstable = 1'b0, rwBad = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      xferIdx = 0; hiCnt = 0; loCnt = 0; pwrCnt = 0;
      holdPending = 1'b0; unstable = 1'b0;
    end else begin
      if (lcdRw !== 1'b0) rwBad = 1'b1;
      if (holdPending) begin
        check(lcdData == latData && lcdRs == latRs, "R7 hold", lcdData, latData);
        holdPending = 1'b0;
      end
      if (lcdEn && !prevE) begin
        check(lcdData == expByte(xferIdx), (xferIdx < 4) ? "R1 cmd order" : "R2 char order",
              lcdData, expByte(xferIdx));
        check(lcdRs == expRs(xferIdx), "R3 select level", lcdRs, expRs(xferIdx));
        check(lcdRw == 1'b0, "R4 rw low", lcdRw, 0);
        check(lcdData == prevData && lcdRs == prevRs, "R7 setup", lcdData, prevData);
        if (xferIdx == 0)
          check(pwrCnt >= EXP_PWR, "R9 power-on wait", pwrCnt, EXP_PWR);
        else
          check(loCnt >= expWait(xferIdx - 1), "R8 exec wait", loCnt, expWait(xferIdx - 1));
        latData = lcdData; latRs = lcdRs; hiCnt = 1; unstable = 1'b0;
      end else if (lcdEn) begin
        hiCnt++;
        if (lcdData != latData || lcdRs != latRs) unstable = 1'b1;
      end else if (prevE) begin
        check(hiCnt >= EXP_EHIGH, "R5 enable width", hiCnt, EXP_EHIGH);
        check(!unstable, "R6 stable while high", unstable, 0);
        xferIdx++; loCnt = 1; holdPending = 1'b1;
      end else begin
        loCnt++;
      end
      if (xferIdx == 0 && !lcdEn) pwrCnt++;
    end
    prevE = lcdEn; prevData = lcdData; prevRs = lcdRs;
  end

  task automatic waitDone();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic checkIdle(input string tag);
    @(negedge clk);
    check(lcdEn == 1'b0, tag, lcdEn, 0);
    check(done == 1'b0, tag, done, 0);
  endtask

  task automatic checkFinished();
    check(done == 1'b1, "R10 done raised", done, 1);
    check(xferIdx == 8, "R10 eight transfers", xferIdx, 8);
    repeat (300) @(negedge clk);
    check(done == 1'b1 && lcdEn == 1'b0, "R10 idle after done", {done, lcdEn}, 2'b10);
    check(xferIdx == 8, "R10 no extra pulse", xferIdx, 8);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (4) @(posedge clk);
    checkIdle("R11 reset state");
    @(negedge clk); rst = 1'b0;
    waitDone();
    checkFinished();

    // Resets injected at random points, plus directed ones in the long waits
    for (int t = 0; t < 6; t++) begin
      int unsigned at;
      case (t)
        0:       at = 200;   // inside the first enable pulse
        1:       at = 500;   // during the wait after the clear command
        default: at = $urandom_range(30, 2400);
      endcase
      @(negedge clk); rst = 1'b1;
      repeat (3) @(posedge clk);
      checkIdle("R11 reset clears outputs");
      @(negedge clk); rst = 1'b0;
      repeat (at) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      checkIdle("R11 mid-run reset");
      @(negedge clk); rst = 1'b0;
      waitDone();
      checkFinished();
    end
    check(!rwBad, "R4 rw never high", rwBad, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", xferIdx, 8);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule